// File: doc/BRIEF.md
# Hidden-Bit Float Compare Unit

This block compares two 64-bit floating-point words held in register layout. The sign sits in bit 63. The exponent sits in bits 62..52 with a bias of 1024. The remaining 52 bits are a fraction with an implied leading one. The format has no infinities and no not-a-number codes. A word whose exponent field is zero is the value zero only when every bit is zero. Any other word with a zero exponent is a reserved operand.

A predicate select picks one of three tests: equal, less-than, or less-or-equal. The unit returns a 64-bit result word that holds a fixed true constant or all zeros. A separate flag reports that an operand was reserved. The unit is purely combinational and sits in the operate stage of a floating-point pipe. Writing the result to a register and delivering a trap for the flag are left to the surrounding logic.

Ordering is taken from the raw bit patterns, not from decoded fields. Identical words are equal. When the signs differ, the negative word is the smaller one. When the signs match, the words are compared as unsigned integers, and the sense is reversed when both are negative.

Top module: `fcmp_unit`

## Requirements
- R1: A word whose bits 62..52 are all zero, but which is not zero in every bit, is reserved. When either operand is reserved, `invalid_o` is 1.
- R2: A word that is zero in every bit is a valid zero. When both operands are valid, `invalid_o` is 0.
- R3: When either operand is reserved, `result_o` is all zeros for every select code.
- R4: Two valid operands with identical 64-bit patterns are equal. Equal and less-or-equal return true, and less-than returns false.
- R5: For valid operands whose bit 63 differs, the operand with bit 63 set is the smaller one.
- R6: For valid operands that both have bit 63 clear, a is less than b exactly when a is below b as a 64-bit unsigned number.
- R7: For valid operands that both have bit 63 set, the unsigned ordering is reversed: a is less than b exactly when a is above b as unsigned.
- R8: Select code 0x25 tests equal, 0x26 tests less-than, and 0x27 tests less-or-equal. A true test gives `result_o` = 0x4000000000000000, and a false test gives all zeros.
- R9: Any select code other than 0x25, 0x26 and 0x27 gives `result_o` all zeros. `invalid_o` still follows R1 for these codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a_i | input | 64 | First operand (left side of the test) |
| op_b_i | input | 64 | Second operand (right side of the test) |
| pred_sel_i | input | 6 | Predicate select code |
| result_o | output | 64 | True constant or all zeros |
| invalid_o | output | 1 | Reserved operand seen on either input |

## Verification
Both outputs are combinational, so each result is due in the same cycle as its inputs, with no register on the way. The bench drives the operands and the select code just after a rising edge. It compares both outputs with its reference model at the following falling edge, half a cycle later, when the paths have settled. Every operand pair is checked under each of the three predicates and under several unused codes. The pairs include mixed signs, negative pairs, zeros and reserved words. The reference orders words through a signed magnitude key instead of the raw-pattern rule, so it does not copy the design's logic.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Summary of one operand as seen by the ordering logic
  typedef struct packed {
    logic sign;
    logic zero;
    logic rsv;
  } op_info_t;

  // Exponent field all zero
  function automatic logic f_exp_clear(input logic [63:0] w, input int unsigned lsb,
                                       input int unsigned width);
    logic clr;
    clr = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i >= lsb && i < lsb + width && w[i]) clr = 1'b0;
    end
    return clr;
  endfunction

  // Raw-pattern less-than with sign-flipped sense (valid operands only)
  function automatic logic f_raw_less(input logic [63:0] a, input logic [63:0] b);
    logic res;
    if (a[63] != b[63]) res = a[63];
    else                res = (a < b) ^ a[63];
    return res;
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned EXP_LSB = 52
) (
  input  logic [WORD_W-1:0] word_i,
  output op_info_t          info_o
);
  localparam int unsigned SIGN_POS = WORD_W - 1;

  logic exp_clear;
  logic all_zero;

  always_comb begin
    exp_clear   = f_exp_clear(64'(word_i), EXP_LSB, EXP_W);
    all_zero    = (word_i == '0);
    info_o.sign = word_i[SIGN_POS];
    info_o.zero = all_zero;
    info_o.rsv  = exp_clear & ~all_zero;
  end

  // R2: an all-zero word is never reserved
  always_comb begin
    a_r2_zero_not_reserved: assert (!(word_i == '0) || !info_o.rsv);
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int unsigned WORD_W = 64
) (
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              eq_o,
  output logic              lt_o
);
  always_comb begin
    eq_o = (a_i == b_i);
    lt_o = eq_o ? 1'b0 : f_raw_less(64'(a_i), 64'(b_i));
  end

  // R4: equal and less-than are never both set
  always_comb begin
    a_r4_eq_excludes_lt: assert (!(eq_o && lt_o));
  end

endmodule

// File: rtl/fcmp_select.sv
module fcmp_select #(
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned SEL_W     = 6,
  parameter logic [SEL_W-1:0] SEL_EQ = 6'h25,
  parameter logic [SEL_W-1:0] SEL_LT = 6'h26,
  parameter logic [SEL_W-1:0] SEL_LE = 6'h27,
  parameter logic [WORD_W-1:0] TRUE_WORD = 64'h4000_0000_0000_0000
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              eq_i,
  input  logic              lt_i,
  input  logic              rsv_i,
  output logic [WORD_W-1:0] result_o
);
  logic hit;

  always_comb begin
    unique case (sel_i)
      SEL_EQ:  hit = eq_i;
      SEL_LT:  hit = lt_i;
      SEL_LE:  hit = eq_i | lt_i;
      default: hit = 1'b0;
    endcase
    result_o = (hit && !rsv_i) ? TRUE_WORD : '0;
  end

  // R8: result is either the true constant or zero
  always_comb begin
    a_r8_result_two_values: assert (result_o == '0 || result_o == TRUE_WORD);
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned WORD_W  = 64,
  parameter int unsigned EXP_W   = 11,
  parameter int unsigned SEL_W   = 6,
  parameter logic [SEL_W-1:0] SEL_EQ = 6'h25,
  parameter logic [SEL_W-1:0] SEL_LT = 6'h26,
  parameter logic [SEL_W-1:0] SEL_LE = 6'h27,
  parameter logic [WORD_W-1:0] TRUE_WORD = 64'h4000_0000_0000_0000
) (
  input  logic [WORD_W-1:0] op_a_i,
  input  logic [WORD_W-1:0] op_b_i,
  input  logic [SEL_W-1:0]  pred_sel_i,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);
  localparam int unsigned EXP_LSB = WORD_W - 1 - EXP_W;
  localparam int unsigned N_OPS   = 2;

  logic [WORD_W-1:0] ops [N_OPS];
  op_info_t          info [N_OPS];
  logic              any_rsv;
  logic              eq_w;
  logic              lt_w;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    fcmp_classify #(
      .WORD_W (WORD_W),
      .EXP_W  (EXP_W),
      .EXP_LSB(EXP_LSB)
    ) u_cls (
      .word_i(ops[g]),
      .info_o(info[g])
    );
  end

  assign any_rsv   = info[0].rsv | info[1].rsv;
  assign invalid_o = any_rsv;

  fcmp_order #(.WORD_W(WORD_W)) u_order (
    .a_i (op_a_i),
    .b_i (op_b_i),
    .eq_o(eq_w),
    .lt_o(lt_w)
  );

  fcmp_select #(
    .WORD_W   (WORD_W),
    .SEL_W    (SEL_W),
    .SEL_EQ   (SEL_EQ),
    .SEL_LT   (SEL_LT),
    .SEL_LE   (SEL_LE),
    .TRUE_WORD(TRUE_WORD)
  ) u_sel (
    .sel_i   (pred_sel_i),
    .eq_i    (eq_w),
    .lt_i    (lt_w),
    .rsv_i   (any_rsv),
    .result_o(result_o)
  );

  always_comb begin
    // R3: a reserved operand never yields a true result
    a_r3_reserved_false: assert (!invalid_o || result_o == '0);
    // R5: mixed valid signs order by the sign bit
    a_r5_mixed_sign: assert (invalid_o || (op_a_i[WORD_W-1] == op_b_i[WORD_W-1])
                             || (lt_w == op_a_i[WORD_W-1]));
    // R9: unused codes give zero
    a_r9_unused_code: assert (pred_sel_i == SEL_EQ || pred_sel_i == SEL_LT
                              || pred_sel_i == SEL_LE || result_o == '0);
  end

endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;
  localparam logic [63:0] TRUE_C = 64'h4000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic [5:0]  sel = '0;
  logic [63:0] result;
  logic        invalid;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  fcmp_unit u_fcmp_unit (
    .op_a_i(a), .op_b_i(b), .pred_sel_i(sel),
    .result_o(result), .invalid_o(invalid)
  );

  function automatic bit m_rsv(input logic [63:0] w);
    return (w[62:52] == 11'd0) && (w != 64'd0);
  endfunction

  // signed magnitude key: independent ordering view
  function automatic logic signed [64:0] m_key(input logic [63:0] w);
    logic signed [64:0] mag;
    mag = {2'b00, w[62:0]};
    return w[63] ? -mag : mag;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h sel=%h actual=%h expected=%h", tag, a, b, sel, act, exp);
    end
  endtask

  task automatic run_case(input logic [63:0] xa, input logic [63:0] xb, input logic [5:0] xs);
    logic [63:0] exp_res;
    bit  bad, tr;
    string tag;
    @(posedge clk);
    #2;
    a = xa; b = xb; sel = xs;
    bad = m_rsv(xa) || m_rsv(xb);
    case (xs)
      6'h25: tr = (xa == xb);
      6'h26: tr = (xa != xb) && (m_key(xa) < m_key(xb));
      6'h27: tr = (xa == xb) || (m_key(xa) < m_key(xb));
      default: tr = 0;
    endcase
    exp_res = (tr && !bad) ? TRUE_C : 64'd0;
    if (bad)                                   tag = "R3";
    else if (xs < 6'h25 || xs > 6'h27)         tag = "R9";
    else if (xa == xb)                         tag = "R4";
    else if (xa[63] != xb[63])                 tag = "R5";
    else if (xa[63])                           tag = "R7";
    else                                       tag = "R6";
    @(negedge clk);
    check({tag, "/R8 result"}, result, exp_res);
    check(bad ? "R1 invalid" : "R2 invalid", {63'd0, invalid}, {63'd0, bad});
  endtask

  initial begin
    logic [63:0] pa [15];
    logic [63:0] pb [15];
    logic [5:0]  codes [6];
    pa[0]  = 64'h4010_0000_0000_0000; pb[0]  = 64'h4010_0000_0000_0000;
    pa[1]  = 64'h4010_0000_0000_0000; pb[1]  = 64'h4020_0000_0000_0000;
    pa[2]  = 64'h4020_0000_0000_0000; pb[2]  = 64'h4010_0000_0000_0000;
    pa[3]  = 64'hC010_0000_0000_0000; pb[3]  = 64'hC020_0000_0000_0000;
    pa[4]  = 64'hC020_0000_0000_0000; pb[4]  = 64'hC010_0000_0000_0000;
    pa[5]  = 64'hC010_0000_0000_0000; pb[5]  = 64'h4010_0000_0000_0000;
    pa[6]  = 64'h4010_0000_0000_0000; pb[6]  = 64'hC010_0000_0000_0000;
    pa[7]  = 64'd0;                   pb[7]  = 64'h4010_0000_0000_0000;
    pa[8]  = 64'hC010_0000_0000_0001; pb[8]  = 64'd0;
    pa[9]  = 64'd0;                   pb[9]  = 64'd0;
    pa[10] = 64'h8000_0000_0000_0000; pb[10] = 64'h4010_0000_0000_0000;
    pa[11] = 64'h0010_0000_0000_0000; pb[11] = 64'h000F_0000_0000_0001;
    pa[12] = 64'h0000_0000_0000_0001; pb[12] = 64'h0000_0000_0000_0001;
    pa[13] = 64'hC010_0000_0000_0001; pb[13] = 64'hC010_0000_0000_0000;
    pa[14] = 64'h4010_0000_0000_0000; pb[14] = 64'h4010_0000_0000_0001;
    codes[0] = 6'h25; codes[1] = 6'h26; codes[2] = 6'h27;
    codes[3] = 6'h00; codes[4] = 6'h24; codes[5] = 6'h3F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs, code 0
    check("R9 idle result", result, 64'd0);
    check("R2 idle invalid", {63'd0, invalid}, 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 15; i++) begin
      for (int k = 0; k < 6; k++) run_case(pa[i], pb[i], codes[k]);
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule